// File: doc/BRIEF.md
# Command-Word Register Access Channel

This block is the host-facing side of a wrapper that lets a bus master reach registers inside a serial power-management device. Software writes one command word. The word holds a direction flag, a register address that has already been halved, and a 16-bit write value. A small state machine then issues a request to the serial back end and waits for the back end to take it. For a read, the machine also waits for the returned data.

After a read completes, the machine does not drop back to idle by itself. It holds the captured value and parks in a wait-for-clear state until software writes 1 to a valid-clear strobe. A status word reports four things: the state code, the held read value, whether the back-end handshake has settled, and an init-done flag. The init-done flag lets callers refuse access before setup has finished.

The serial back end is seen only as three signals: a request/acknowledge pair and a read-data valid pulse.

Top module: `regacc_chan`

## Requirements
- R1: In a command word, bit 31 is the direction (1 = write, 0 = read), bits 30:16 are the halved register address and bits 15:0 are the write value. Once a command is accepted, `be_we`, `be_addr` and `be_wdata` carry these three fields. They stay unchanged until the next accepted command.
- R2: A command strobe is accepted only while the state is IDLE (code 0). One cycle later the state is REQ (code 2). `be_req` is high exactly while the state is REQ, and it stays high until `be_ack` is seen.
- R3: For a write, a `be_ack` seen in REQ returns the state to IDLE on the next cycle.
- R4: For a read, a `be_ack` seen in REQ moves the state to WFDLE (code 4). A `be_rvalid` seen in WFDLE moves it to WFVLDCLR (code 6). `be_ack` outside REQ and `be_rvalid` outside WFDLE have no effect.
- R5: A valid-clear strobe carrying the value 1 while in WFVLDCLR returns the state to IDLE. A strobe carrying 0, or a strobe in any other state, has no effect.
- R6: Status bits 15:0 show the read value captured on `be_rvalid` in WFDLE. This value changes at no other time.
- R7: Status bits 18:16 hold the state code. Status bit 19 (sync-idle) is 1 exactly when the state is IDLE or WFVLDCLR, that is, when no back-end handshake is outstanding.
- R8: Status bit 20 shows the init-done register. A write strobe to that register loads its value. Status bits 31:21 read as 0.
- R9: A command strobe arriving while the state is not IDLE is dropped. It sets `overrun`, which stays set until reset.
- R10: After synchronous reset, the state is IDLE, the read value is 0, init-done is 0, `overrun` is 0, the captured command fields are 0 and sync-idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word: direction, halved address, write value |
| vclr_wr | input | 1 | Valid-clear write strobe |
| vclr_val | input | 1 | Value written with the valid-clear strobe |
| init_wr | input | 1 | Init-done register write strobe |
| init_val | input | 1 | Value written to the init-done register |
| status_word | output | 32 | Read value, state code, sync-idle, init-done |
| overrun | output | 1 | Sticky flag for a command dropped while busy |
| be_req | output | 1 | Request to the serial back end |
| be_we | output | 1 | Direction of the outstanding request |
| be_addr | output | 15 | Halved register address of the request |
| be_wdata | output | 16 | Write value of the request |
| be_ack | input | 1 | Back end has taken the request |
| be_rvalid | input | 1 | Back end returns read data |
| be_rdata | input | 16 | Returned read data |

## Verification
Writes and reads are run with back-end acknowledge and data latencies that range from immediate to several cycles. These show whether the request is held for the whole wait and whether writes skip the data and clear states. Stray stimulus is then applied: acknowledges and data pulses in the wrong state, a valid-clear carrying 0, a valid-clear while idle, and commands issued while busy. These separate real transitions from ignored ones, and confirm that the held read value and the sticky overrun flag survive them. Init-done toggling and a reset in the middle of a read confirm that the status flags are independent of the transfer path.

// File: rtl/regacc_pkg.sv
// Shared constants for the register access channel: state codes and
// status word field positions. Assumes a 3-bit state code.
package regacc_pkg;
    localparam int ST_W       = 3;
    localparam logic [ST_W-1:0] ST_IDLE  = 3'd0;
    localparam logic [ST_W-1:0] ST_REQ   = 3'd2;
    localparam logic [ST_W-1:0] ST_WFDAT = 3'd4;
    localparam logic [ST_W-1:0] ST_WFCLR = 3'd6;
    // Extra status bits above the data field: state, sync-idle, init-done.
    localparam int STAT_XTRA  = ST_W + 2;
endpackage

// File: rtl/regacc_cmd_dec.sv
// Command word decoder: splits an accepted command into direction,
// halved address and write value, and holds them for the back end.
// Assumes load is only raised when the channel is idle.
module regacc_cmd_dec #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15,
    localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              busy,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    // Capture the command fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            we_q    <= cmd_word[CMD_W-1];
            addr_q  <= cmd_word[CMD_W-2:DATA_W];
            wdata_q <= cmd_word[DATA_W-1:0];
        end
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(we_q) && $stable(addr_q) && $stable(wdata_q))); // R1
endmodule

// File: rtl/regacc_fsm.sv
// Channel state machine: request, wait for data, wait for valid-clear.
// Unused state codes fall back to idle. Also keeps the sticky overrun
// flag for commands that arrive while busy.
module regacc_fsm
    import regacc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic            cmd_we,
    input  logic            be_ack,
    input  logic            be_rvalid,
    input  logic            vclr_wr,
    input  logic            vclr_val,
    output logic [ST_W-1:0] state,
    output logic            accept,
    output logic            capture,
    output logic            overrun
);
    logic [ST_W-1:0] st_q, st_d;
    logic            ovr_q;

    assign state   = st_q;
    assign accept  = cmd_wr && (st_q == ST_IDLE);
    assign capture = be_rvalid && (st_q == ST_WFDAT);
    assign overrun = ovr_q;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (cmd_wr)              st_d = ST_REQ;
            ST_REQ:   if (be_ack)              st_d = cmd_we ? ST_IDLE : ST_WFDAT;
            ST_WFDAT: if (be_rvalid)           st_d = ST_WFCLR;
            ST_WFCLR: if (vclr_wr && vclr_val) st_d = ST_IDLE;
            default:                           st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sticky overrun on a command strobe while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovr_q <= 1'b0;
        else if (cmd_wr && st_q != ST_IDLE)  ovr_q <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REQ && !be_ack) |=> (st_q == ST_REQ)); // R2
    AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REQ && be_ack && cmd_we) |=> (st_q == ST_IDLE)); // R3
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_REQ || st_q == ST_WFDAT || st_q == ST_WFCLR)); // R4
    AST_CLR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WFCLR && !(vclr_wr && vclr_val)) |=> (st_q == ST_WFCLR)); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q); // R9
endmodule

// File: rtl/regacc_status.sv
// Status word builder: holds the captured read value and the init-done
// register and packs them with the state code and sync-idle flag.
module regacc_status
    import regacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 32,
    localparam int PAD_W = OUT_W - DATA_W - STAT_XTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] be_rdata,
    input  logic              init_wr,
    input  logic              init_val,
    input  logic [ST_W-1:0]   state,
    output logic [OUT_W-1:0]  status_word
);
    logic [DATA_W-1:0] rd_q;
    logic              init_q;
    logic              sync_idle;

    // Hold read data from capture until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (capture) rd_q <= be_rdata;
    end

    // Software-written init-done register.
    always_ff @(posedge clk) begin
        if (!rst_n)       init_q <= 1'b0;
        else if (init_wr) init_q <= init_val;
    end

    // No handshake outstanding in idle or while parked for clear.
    assign sync_idle   = (state == ST_IDLE) || (state == ST_WFCLR);
    assign status_word = {{PAD_W{1'b0}}, init_q, sync_idle, state, rd_q};

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_q)); // R6
endmodule

// File: rtl/regacc_chan.sv
// Register access channel top: accepts a command word, drives a
// req/ack back end, parks reads until software clears them, and
// reports everything through one status word.
module regacc_chan
    import regacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15,
    localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              vclr_wr,
    input  logic              vclr_val,
    input  logic              init_wr,
    input  logic              init_val,
    output logic [CMD_W-1:0]  status_word,
    output logic              overrun,
    output logic              be_req,
    output logic              be_we,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_ack,
    input  logic              be_rvalid,
    input  logic [DATA_W-1:0] be_rdata
);
    logic [ST_W-1:0] state;
    logic            accept, capture;

    regacc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_we(be_we),
        .be_ack(be_ack), .be_rvalid(be_rvalid),
        .vclr_wr(vclr_wr), .vclr_val(vclr_val),
        .state(state), .accept(accept), .capture(capture), .overrun(overrun)
    );

    regacc_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .load(accept), .cmd_word(cmd_word),
        .busy(state != ST_IDLE),
        .we_q(be_we), .addr_q(be_addr), .wdata_q(be_wdata)
    );

    regacc_status #(.DATA_W(DATA_W), .OUT_W(CMD_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .capture(capture), .be_rdata(be_rdata),
        .init_wr(init_wr), .init_val(init_val), .state(state),
        .status_word(status_word)
    );

    // Request is raised for the whole REQ state.
    assign be_req = (state == ST_REQ);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_wr) |=> be_req); // R2
endmodule

// File: tb/sim_regacc_chan.sv
module sim_regacc_chan;
    logic        clk = 0, rst_n = 0;
    logic        cmd_wr = 0, vclr_wr = 0, vclr_val = 0, init_wr = 0, init_val = 0;
    logic [31:0] cmd_word = 0;
    logic        be_ack = 0, be_rvalid = 0;
    logic [15:0] be_rdata = 0;
    logic [31:0] status_word;
    logic        overrun, be_req, be_we;
    logic [14:0] be_addr;
    logic [15:0] be_wdata;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0, chk_en = 0;

    // Behavioural reference state
    int m_st = 0; bit m_we = 0; int m_addr = 0, m_wd = 0, m_rd = 0;
    bit m_init = 0, m_ovr = 0;

    regacc_chan u0 (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        int n;
        if (!rst_n) begin
            m_st = 0; m_we = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_init = 0; m_ovr = 0;
        end else begin
            n = m_st;
            case (m_st)
                0: if (cmd_wr) begin
                       n = 2; m_we = cmd_word[31];
                       m_addr = cmd_word[30:16]; m_wd = cmd_word[15:0];
                   end
                2: if (be_ack) n = m_we ? 0 : 4;
                4: if (be_rvalid) begin n = 6; m_rd = be_rdata; end
                6: if (vclr_wr && vclr_val) n = 0;
                default: n = 0;
            endcase
            if (cmd_wr && m_st != 0) m_ovr = 1;
            if (init_wr) m_init = init_val;
            m_st = n;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cycles++;
        if (chk_en) begin
            chk("R7", "state", {29'b0, status_word[18:16]}, m_st);
            chk("R7", "sync_idle", {31'b0, status_word[19]}, (m_st == 0 || m_st == 6) ? 1 : 0);
            chk("R6", "rdata", {16'b0, status_word[15:0]}, m_rd);
            chk("R8", "init_done", {31'b0, status_word[20]}, {31'b0, m_init});
            chk("R8", "pad", {21'b0, status_word[31:21]}, 0);
            chk("R9", "overrun", {31'b0, overrun}, {31'b0, m_ovr});
            chk("R2", "be_req", {31'b0, be_req}, (m_st == 2) ? 1 : 0);
            chk("R1", "be_we", {31'b0, be_we}, {31'b0, m_we});
            chk("R1", "be_addr", {17'b0, be_addr}, m_addr);
            chk("R1", "be_wdata", {16'b0, be_wdata}, m_wd);
        end
    endtask

    task automatic idle_n(int k);
        for (int i = 0; i < k; i++) cyc();
    endtask

    task automatic issue(bit we, logic [14:0] a, logic [15:0] d);
        cmd_wr = 1; cmd_word = {we, a, d}; cyc(); cmd_wr = 0;
    endtask

    // R3: write with ack latency
    task automatic do_write(logic [14:0] a, logic [15:0] d, int ackdly);
        issue(1, a, d);
        idle_n(ackdly);
        be_ack = 1; cyc(); be_ack = 0;
        cyc();
    endtask

    // R4/R5: read with ack and data latency, then park and clear
    task automatic do_read(logic [14:0] a, logic [15:0] rv, int ackdly, int datdly, int park);
        issue(0, a, 16'h0);
        idle_n(ackdly);
        be_ack = 1; cyc(); be_ack = 0;
        idle_n(datdly);
        be_rvalid = 1; be_rdata = rv; cyc(); be_rvalid = 0; be_rdata = 16'hdead;
        idle_n(park);
        vclr_wr = 1; vclr_val = 1; cyc(); vclr_wr = 0; vclr_val = 0;
        cyc();
    endtask

    initial begin
        idle_n(3);
        rst_n = 1; chk_en = 1;
        cyc();                                   // R10 reset state
        chk("R10", "status_after_reset", status_word, 32'h0008_0000);
        do_write(15'h1234, 16'hbeef, 0);         // R1 R3 immediate ack
        do_write(15'h7fff, 16'h0001, 4);         // R2 held request
        do_read(15'h0abc, 16'h5a5a, 0, 0, 0);    // R4 fastest read
        do_read(15'h0001, 16'ha5c3, 3, 5, 6);    // R4 R6 slow read, long park
        // R4: stray ack/rvalid ignored in idle
        be_ack = 1; be_rvalid = 1; be_rdata = 16'h1111; cyc(); be_ack = 0; be_rvalid = 0; cyc();
        // R4: rvalid during REQ ignored
        issue(0, 15'h0042, 16'h0);
        be_rvalid = 1; be_rdata = 16'h2222; cyc(); be_rvalid = 0;
        be_ack = 1; cyc(); be_ack = 0;
        be_ack = 1; cyc(); be_ack = 0;           // ack in WFDLE ignored
        be_rvalid = 1; be_rdata = 16'h3c3c; cyc(); be_rvalid = 0;
        // R6: rvalid in park ignored; R5: clear with 0 ignored
        be_rvalid = 1; be_rdata = 16'h4444; cyc(); be_rvalid = 0;
        vclr_wr = 1; vclr_val = 0; cyc(); vclr_wr = 0;
        idle_n(2);
        // R9: command while parked dropped
        issue(1, 15'h0555, 16'h6666);
        idle_n(2);
        vclr_wr = 1; vclr_val = 1; cyc(); vclr_wr = 0; vclr_val = 0;
        // R5: clear in idle ignored
        vclr_wr = 1; vclr_val = 1; cyc(); vclr_wr = 0; vclr_val = 0;
        // R8: init-done toggling
        init_wr = 1; init_val = 1; cyc(); init_wr = 0; idle_n(2);
        init_val = 0; cyc();                     // value without strobe ignored
        do_write(15'h0100, 16'h0f0f, 1);
        init_wr = 1; init_val = 0; cyc(); init_wr = 0; cyc();
        init_wr = 1; init_val = 1; cyc(); init_wr = 0;
        // R9: command during REQ dropped, overrun sticky
        issue(1, 15'h0200, 16'h1357);
        issue(0, 15'h0300, 16'h9999);
        idle_n(2);
        be_ack = 1; cyc(); be_ack = 0;
        idle_n(3);
        // R10: reset in the middle of a read
        issue(0, 15'h0777, 16'h0);
        be_ack = 1; cyc(); be_ack = 0;
        rst_n = 0; cyc(); cyc(); rst_n = 1;
        cyc();
        chk("R10", "status_after_mid_reset", status_word, 32'h0008_0000);
        chk("R10", "overrun_after_mid_reset", {31'b0, overrun}, 0);
        do_read(15'h0010, 16'hffff, 1, 1, 1);
        idle_n(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule